// File: doc/BRIEF.md
# Triggered One-Shot Delay Timer Channel

This block is one timer channel that produces a programmable delay. Software loads a 16-bit delay value and arms the channel with a start strobe. The armed channel does not count yet. It waits for a start trigger, which is either a chosen edge on an external input pin or another start strobe. On each trigger the delay value is copied into the count register. The count register then steps down once for every pulse on the count-clock enable. When the count reaches zero, the channel raises a one-cycle interrupt and stays idle until the next trigger.

The external trigger input is first synchronized. An optional filter can then be switched in, which accepts a new level only after it has been seen on two consecutive clocks. The active edge is selectable as rising, falling or both. A trigger that arrives while a count is running restarts the count from the delay value.

A stop strobe disarms the channel and freezes the count. A unit-level enable input gates the whole channel: while it is low, register writes are dropped and every piece of state returns to its reset value. The count value is always visible on an output port.

Top module: `dly_chan_top`

## Requirements
- R1: While `unit_en` is low, all channel state returns to reset values on each clock: the count reads 0, the channel is disarmed, and the delay, filter and edge settings are 0. Register writes made while `unit_en` is low have no effect.
- R2: A start strobe (`wr_sel`=1, `wr_data[0]`=1) on a disarmed channel only arms it. The count register does not change, and count-enable pulses do not move it.
- R3: A start strobe on an armed channel is a start trigger. At the next clock edge, the count register takes the value of the delay register (`wr_sel`=0, written from `wr_data[15:0]`).
- R4: After a trigger, the count register decreases by exactly one at each clock where `cnt_tick` is high. It holds its value on clocks where `cnt_tick` is low.
- R5: In the cycle after the tick that brings the count to 0, `irq_o` is high for exactly one cycle. Further ticks leave the count at 0 and do not raise `irq_o` again. `irq_o` is never high while the count is non-zero.
- R6: Rewriting the delay register while a count is running does not change the running count. The new value is loaded at the next trigger.
- R7: A stop strobe (`wr_sel`=1, `wr_data[1]`=1; it takes priority over the start bit) disarms the channel and freezes the count. Later ticks and input edges leave the count unchanged. The next start strobe only re-arms the channel.
- R8: The edge mode field (`wr_sel`=2, `wr_data[2:1]`) selects the trigger edge on `trig_in`: 0 selects rising, 1 selects falling, and 2 or 3 selects both. An edge of the other polarity does not reload the count.
- R9: The filter enable bit (`wr_sel`=2, `wr_data[0]`) selects filtering. With the bit set, a `trig_in` pulse lasting one clock is rejected, and a level held for four clocks is accepted as an edge. With the bit clear, a one-clock pulse is detected.
- R10: A trigger that arrives while a count is in progress reloads the delay value and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Unit-level enable; low holds the channel in reset |
| cnt_tick | input | 1 | Count-clock enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 delay, 1 command, 2 mode |
| wr_data | input | 16 | Write data |
| trig_in | input | 1 | External trigger pin, asynchronous |
| count_o | output | 16 | Current count register value |
| irq_o | output | 1 | One-cycle interrupt at terminal count |

## Verification
The assertions assume that `unit_en`, `cnt_tick` and the write port are synchronous to `clk`, and that the delay value seen at a trigger is the one held in the register before that edge. They also assume that `trig_in` is the only asynchronous input. The stimulus changes every synchronous input one time unit after a rising edge and holds each write for exactly one cycle. It also holds `cnt_tick` low while it inspects a freshly loaded count, so that a load can always be told apart from a decrement.

// File: rtl/dly_chan_pkg.sv
package dly_chan_pkg;
    localparam int CNT_W   = 16;
    localparam int SEL_W   = 2;

    localparam logic [SEL_W-1:0] SEL_DELAY = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CMD   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MODE  = 2'd2;

    // command bit positions
    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;

    // mode field positions
    localparam int MODE_FILT = 0;
    localparam int MODE_EDGE = 1;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] dly;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             run;
        logic             irq;
        logic             filt_on;
        edge_mode_e       mode;
    } chan_state_t;
endpackage

// File: rtl/dly_trig_filter.sv
module dly_trig_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw_in,
    input  logic filt_on,
    output logic lvl_o
);
    localparam int HW = FILT_LEN - 1;

    typedef struct packed {
        logic [SYNC_LEN-1:0] sync;
        logic [HW-1:0]       hist;
        logic                lvl;
    } filt_t;

    filt_t q, d;
    logic  s_last;
    logic  [HW:0] window;
    logic  all_same;

    always_comb begin
        s_last   = q.sync[SYNC_LEN-1];
        window   = {q.hist, s_last};
        all_same = (&window) | ~(|window);
        d        = q;
        d.sync   = {q.sync[SYNC_LEN-2:0], raw_in};
        d.hist   = window[HW-1:0];
        if (filt_on) begin
            d.lvl = all_same ? s_last : q.lvl;
        end else begin
            d.lvl = s_last;
        end
        if (clr) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lvl_o = q.lvl;
endmodule

// File: rtl/dly_edge_pick.sv
module dly_edge_pick
    import dly_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       lvl,
    input  edge_mode_e mode,
    output logic       hit_o
);
    logic prev_q, prev_d;
    logic rise, fall;

    always_comb begin
        prev_d = clr ? 1'b0 : lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
        unique case (mode)
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            default:   hit_o = rise | fall;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/dly_chan_top.sv
module dly_chan_top
    import dly_chan_pkg::*;
#(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_en,
    input  logic             cnt_tick,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             trig_in,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    chan_state_t q, d;
    logic        wr_ok, start_w, stop_w, fire_w, hit_w, lvl_w;
    logic [CNT_W-1:0] dly_w;

    dly_trig_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .clr(~unit_en),
        .raw_in(trig_in), .filt_on(q.filt_on), .lvl_o(lvl_w)
    );

    dly_edge_pick u_edge (
        .clk(clk), .rst_n(rst_n), .clr(~unit_en),
        .lvl(lvl_w), .mode(q.mode), .hit_o(hit_w)
    );

    always_comb begin
        wr_ok   = unit_en & wr_en;
        start_w = wr_ok & (wr_sel == SEL_CMD) & wr_data[CMD_START];
        stop_w  = wr_ok & (wr_sel == SEL_CMD) & wr_data[CMD_STOP];
        fire_w  = unit_en & q.armed & ~stop_w & (hit_w | start_w);

        d     = q;
        d.irq = 1'b0;
        if (wr_ok && wr_sel == SEL_DELAY) begin
            d.dly = wr_data;
        end
        if (wr_ok && wr_sel == SEL_MODE) begin
            d.filt_on = wr_data[MODE_FILT];
            d.mode    = edge_mode_e'(wr_data[MODE_EDGE +: 2]);
        end
        if (stop_w) begin
            d.armed = 1'b0;
            d.run   = 1'b0;
        end else if (start_w && !q.armed) begin
            d.armed = 1'b1;
        end
        if (fire_w) begin
            d.cnt = q.dly;
            d.run = 1'b1;
        end else if (d.run && cnt_tick) begin
            if (q.cnt <= CNT_W'(1)) begin
                d.cnt = '0;
                d.run = 1'b0;
                d.irq = 1'b1;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
        if (!unit_en) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dly_w   = q.dly;
    assign count_o = q.cnt;
    assign irq_o   = q.irq;
endmodule

// File: rtl/dly_chan_chk.sv
module dly_chan_chk
    import dly_chan_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             unit_en,
    input logic             cnt_tick,
    input logic             fire,
    input logic             stop,
    input logic [CNT_W-1:0] dly,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o
);
    // R5
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count_o == '0));

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R1
    unit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (count_o == '0 && !irq_o));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (count_o == $past(dly)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && !fire && !cnt_tick) |=> $stable(count_o));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> ($stable(count_o) && !irq_o));
endmodule

bind dly_chan_top dly_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cnt_tick(cnt_tick),
    .fire(fire_w), .stop(stop_w), .dly(dly_w),
    .count_o(count_o), .irq_o(irq_o)
);

// File: tb/sim_dly_chan_top.sv
module sim_dly_chan_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unit_en = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        trig_in = 1'b0;
    logic [15:0] count_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;

    always #5 clk = ~clk;

    dly_chan_top u0 (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cnt_tick(cnt_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .trig_in(trig_in),
        .count_o(count_o), .irq_o(irq_o)
    );

    always @(posedge clk) if (irq_o) irq_seen <= irq_seen + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_tick = 1'b1;
            @(posedge clk); #1;
            cnt_tick = 1'b0;
        end
    endtask

    task automatic start(); wr(2'd1, 16'h0001); endtask
    task automatic stop();  wr(2'd1, 16'h0002); endtask
    task automatic mode(input logic [1:0] e, input logic f);
        wr(2'd2, {13'd0, e, f});
    endtask

    task automatic t_reset();
        chk("R1 reset count", count_o, 0);
        chk("R1 reset irq", irq_o, 0);
    endtask

    task automatic t_arm_only();
        wr(2'd0, 16'd5);
        start();
        chk("R2 arm does not load", count_o, 0);
        tick(3);
        chk("R2 ticks ignored while waiting", count_o, 0);
    endtask

    task automatic t_sw_trigger();
        start();
        chk("R3 software trigger loads", count_o, 5);
        idle(3);
        chk("R4 holds without tick", count_o, 5);
    endtask

    task automatic t_countdown();
        int base;
        base = irq_seen;
        tick(4);
        chk("R4 four ticks", count_o, 1);
        chk("R5 no irq before zero", irq_o, 0);
        tick(1);
        chk("R5 reaches zero", count_o, 0);
        chk("R5 irq raised", irq_o, 1);
        idle(1);
        chk("R5 irq one cycle", irq_o, 0);
        tick(3);
        chk("R5 stays at zero", count_o, 0);
        chk("R5 single irq pulse", irq_seen - base, 1);
    endtask

    task automatic t_rewrite();
        start();
        tick(2);
        chk("R6 running count", count_o, 3);
        wr(2'd0, 16'd9);
        chk("R6 rewrite leaves count", count_o, 3);
        tick(1);
        chk("R6 keeps old sequence", count_o, 2);
        start();
        chk("R6 new delay at trigger", count_o, 9);
    endtask

    task automatic t_retrigger();
        tick(2);
        chk("R10 counting", count_o, 7);
        start();
        chk("R10 retrigger reloads", count_o, 9);
        tick(2);
    endtask

    task automatic t_stop();
        stop();
        chk("R7 stop freezes", count_o, 7);
        tick(3);
        chk("R7 ticks ignored after stop", count_o, 7);
        mode(2'd2, 1'b0);
        trig_in = 1'b1; idle(6);
        trig_in = 1'b0; idle(6);
        chk("R7 edges ignored after stop", count_o, 7);
        start();
        chk("R7 first start only arms", count_o, 7);
        start();
        chk("R7 second start loads", count_o, 9);
    endtask

    task automatic edge_case(input logic lvl, input logic exp_load, input string tag);
        start();
        tick(3);
        trig_in = lvl;
        idle(6);
        chk(tag, count_o, exp_load ? 20 : 17);
    endtask

    task automatic t_edges();
        wr(2'd0, 16'd20);
        mode(2'd0, 1'b0);
        edge_case(1'b1, 1'b1, "R8 rise mode rising edge");
        edge_case(1'b0, 1'b0, "R8 rise mode falling edge");
        mode(2'd1, 1'b0);
        edge_case(1'b1, 1'b0, "R8 fall mode rising edge");
        edge_case(1'b0, 1'b1, "R8 fall mode falling edge");
        mode(2'd2, 1'b0);
        edge_case(1'b1, 1'b1, "R8 both mode rising edge");
        edge_case(1'b0, 1'b1, "R8 both mode falling edge");
    endtask

    task automatic pulse_case(input int len, input logic exp_load, input string tag);
        start();
        tick(3);
        trig_in = 1'b1;
        idle(len);
        trig_in = 1'b0;
        idle(8);
        chk(tag, count_o, exp_load ? 20 : 17);
    endtask

    task automatic t_filter();
        mode(2'd2, 1'b1);
        pulse_case(1, 1'b0, "R9 filter rejects short pulse");
        pulse_case(4, 1'b1, "R9 filter accepts held level");
        mode(2'd2, 1'b0);
        pulse_case(1, 1'b1, "R9 unfiltered short pulse");
    endtask

    task automatic t_unit_off();
        unit_en = 1'b0;
        idle(1);
        chk("R1 unit off clears count", count_o, 0);
        wr(2'd0, 16'd3);
        start();
        start();
        unit_en = 1'b1;
        idle(1);
        chk("R1 writes ignored while off", count_o, 0);
        start();
        chk("R1 disarmed after unit off", count_o, 0);
        start();
        chk("R1 delay was reset", count_o, 0);
        tick(1);
        chk("R1 zero delay fires at once", irq_o, 1);
        wr(2'd0, 16'd4);
        start();
        chk("R1 rearmed channel loads", count_o, 4);
    endtask

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        unit_en = 1'b1;
        idle(1);
        t_reset();
        t_arm_only();
        t_sw_trigger();
        t_countdown();
        t_rewrite();
        t_retrigger();
        t_stop();
        t_edges();
        t_filter();
        t_unit_off();
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule